// File: doc/BRIEF.md
# Dual-Trigger Clocked One-Shot

This block is a monostable pulse generator built from a clock and a counter rather than from a resistor and a capacitor. A pulse starts on any of three trigger events. The first is a falling edge on the fall trigger input, counted only while the rise trigger input is high. The second is a rising edge on the rise trigger input, counted only while the fall trigger input is low. The third is the release of the active-low clear input. Once started, the true output stays high for a number of clock cycles taken from a load value, and then drops on its own. A second output always carries the complement.

All three inputs may be asynchronous to the clock. They pass through a two-stage synchroniser and then an edge detector, so each qualified edge gives one trigger event lasting a single cycle. A control state machine with two states, `ST_IDLE` and `ST_HOLD`, owns the pulse. Each cycle it takes one named transition. `TR_START` goes from IDLE to HOLD. `TR_RESTART` goes from HOLD to HOLD and reloads the counter. `TR_COUNT` goes from HOLD to HOLD and decrements the counter. `TR_EXPIRE` goes from HOLD to IDLE when the counter reaches zero. `TR_ABORT` goes from either state to IDLE while the synchronised clear is low. `TR_NONE` leaves IDLE where it is.

The build parameter `RETRIG` picks the behaviour when a trigger arrives during a pulse. With `RETRIG` set to 1 the pulse restarts its full length. With `RETRIG` set to 0 the trigger is ignored. To disable a channel, hold its clear input low.

Top module: `oneshot_pulse`

## Requirements
- R1: A falling edge on `fire_fall_i` while `fire_rise_i` is high starts a pulse. `pulse_o` is first seen high after the third rising clock edge that follows the input change.
- R2: A rising edge on `fire_rise_i` while `fire_fall_i` is low starts a pulse, with the same three-edge latency as R1.
- R3: A low-to-high transition of `clear_ni` starts a pulse, with the same three-edge latency as R1.
- R4: Once the synchronised clear is low, any pulse in progress is abandoned. Triggers that arrive while clear is low never start a pulse. After the release, only the pulse started by the release itself is seen.
- R5: `pulse_o` is forced low combinationally in the same cycle that `clear_ni` is low.
- R6: A started pulse keeps `pulse_o` high for exactly `len_i` cycles, where `len_i` is an unsigned cycle count read on the clock edge at which the pulse starts. The pulse then returns low without further input.
- R7: With `RETRIG`=1, a trigger during a pulse restarts the count, so the pulse ends `len_i` cycles after the retrigger takes effect.
- R8: With `RETRIG`=0, triggers during a pulse are ignored, and the pulse ends `len_i` cycles after it started.
- R9: Edges that do not qualify start nothing. These are a fall on `fire_fall_i` while `fire_rise_i` is low, a rise on `fire_rise_i` while `fire_fall_i` is high, a rising edge on `fire_fall_i`, and a falling edge on `fire_rise_i`. Each qualified edge yields exactly one single-cycle trigger event.
- R10: A trigger that reads `len_i` equal to 0 starts no pulse.
- R11: `pulse_no` is always the inverse of `pulse_o`.
- R12: During reset `pulse_o` is low. After reset, with clear high, no pulse appears until a trigger occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fire_fall_i | input | 1 | Trigger input that fires on a falling edge |
| fire_rise_i | input | 1 | Trigger input that fires on a rising edge |
| clear_ni | input | 1 | Active-low clear; its release is also a trigger |
| len_i | input | LEN_W | Pulse length in clock cycles |
| pulse_o | output | 1 | True pulse output |
| pulse_no | output | 1 | Complement of `pulse_o` |

## Verification
A trigger input change made between clock edges shows up on `pulse_o` after the third rising edge. That is two synchroniser stages and then the state register, with the edge detector comparing the second stage against its previous value in between. The pulse then stays high for exactly `len_i` samples. The clear gating on `pulse_o` acts within the same cycle, while the clear's effect on the state arrives after the two synchroniser edges. The bench drives inputs one time unit after each falling edge and samples just after the falling edge. Its reference functions advance a shift-register history of the inputs by the same three-edge offset and compare both build variants cycle by cycle. Directed tests check latency at the first, second and third falling edges after a change, and they count high samples over windows wide enough to cover the full pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Control states of the pulse machine
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

    // Named transitions taken each cycle
    typedef enum logic [2:0] {
        TR_NONE    = 3'd0,
        TR_START   = 3'd1,
        TR_RESTART = 3'd2,
        TR_COUNT   = 3'd3,
        TR_EXPIRE  = 3'd4,
        TR_ABORT   = 3'd5
    } hold_tr_e;

    // Bit positions of the synchronised input vector
    localparam int IDX_FALL = 0;
    localparam int IDX_RISE = 1;
    localparam int IDX_CLR  = 2;
    localparam int NUM_IN   = 3;

    // Rest levels chosen so that reset release never looks like a trigger:
    // fall input low, rise input high, clear high
    localparam logic [NUM_IN-1:0] IN_REST = 3'b110;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int            N       = 3,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    logic [N-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) pipe[g] <= RST_VAL;
                    else         pipe[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) pipe[g] <= RST_VAL;
                    else         pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
    import oneshot_pkg::*;
#(
    parameter logic [NUM_IN-1:0] RST_VAL = IN_REST
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_IN-1:0] lvl_i,
    output logic [NUM_IN-1:0] ev_o,
    output logic              any_o
);

    logic [NUM_IN-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= RST_VAL;
        else         prev_q <= lvl_i;
    end

    always_comb begin
        // falling edge, qualified by rise input high
        ev_o[IDX_FALL] = prev_q[IDX_FALL] & ~lvl_i[IDX_FALL] & lvl_i[IDX_RISE];
        // rising edge, qualified by fall input low
        ev_o[IDX_RISE] = lvl_i[IDX_RISE] & ~prev_q[IDX_RISE] & ~lvl_i[IDX_FALL];
        // release of clear
        ev_o[IDX_CLR]  = lvl_i[IDX_CLR] & ~prev_q[IDX_CLR];
    end

    assign any_o = |ev_o;

endmodule

// File: rtl/oneshot_hold_fsm.sv
module oneshot_hold_fsm
    import oneshot_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter bit RETRIG = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             kill_i,
    input  logic             fire_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             gate_i,
    output logic             active_o,
    output logic [LEN_W-1:0] remain_o,
    output logic             pulse_o,
    output logic             pulse_no
);

    hold_state_e      state_q, state_d;
    hold_tr_e         tr;
    logic [LEN_W-1:0] remain_q;
    logic             len_nz;

    assign len_nz = (len_i != '0);

    // Transition selection; clear has priority over every trigger
    always_comb begin
        tr = TR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (kill_i)                tr = TR_ABORT;
                else if (fire_i && len_nz) tr = TR_START;
                else                       tr = TR_NONE;
            end
            ST_HOLD: begin
                if (kill_i)                          tr = TR_ABORT;
                else if (RETRIG && fire_i && len_nz) tr = TR_RESTART;
                else if (remain_q == '0)             tr = TR_EXPIRE;
                else                                 tr = TR_COUNT;
            end
            default: tr = TR_ABORT;
        endcase
    end

    always_comb begin
        unique case (tr)
            TR_START, TR_RESTART, TR_COUNT: state_d = ST_HOLD;
            TR_EXPIRE, TR_ABORT:            state_d = ST_IDLE;
            default:                        state_d = state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Remaining-cycle counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            remain_q <= '0;
        end else begin
            unique case (tr)
                TR_START, TR_RESTART: remain_q <= len_i - 1'b1;
                TR_COUNT:             remain_q <= remain_q - 1'b1;
                TR_EXPIRE, TR_ABORT:  remain_q <= '0;
                default:              remain_q <= remain_q;
            endcase
        end
    end

    // Outputs; the raw clear gates the pulse off at once
    always_comb begin
        active_o = (state_q == ST_HOLD);
        remain_o = remain_q;
        pulse_o  = active_o & gate_i;
        pulse_no = ~pulse_o;
    end

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
    import oneshot_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter bit RETRIG      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fire_fall_i,
    input  logic             fire_rise_i,
    input  logic             clear_ni,
    input  logic [LEN_W-1:0] len_i,
    output logic             pulse_o,
    output logic             pulse_no
);

    logic [NUM_IN-1:0] raw_vec;
    logic [NUM_IN-1:0] sync_vec;
    logic [NUM_IN-1:0] fire_ev;
    logic              fire_any;
    logic              clr_sync;
    logic              hold_active;
    logic [LEN_W-1:0]  hold_remain;

    always_comb begin
        raw_vec           = '0;
        raw_vec[IDX_FALL] = fire_fall_i;
        raw_vec[IDX_RISE] = fire_rise_i;
        raw_vec[IDX_CLR]  = clear_ni;
    end

    oneshot_sync #(
        .N       (NUM_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_REST)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_vec),
        .q_o    (sync_vec)
    );

    assign clr_sync = sync_vec[IDX_CLR];

    oneshot_edge #(
        .RST_VAL (IN_REST)
    ) edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (sync_vec),
        .ev_o   (fire_ev),
        .any_o  (fire_any)
    );

    oneshot_hold_fsm #(
        .LEN_W  (LEN_W),
        .RETRIG (RETRIG)
    ) fsm_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .kill_i   (~clr_sync),
        .fire_i   (fire_any),
        .len_i    (len_i),
        .gate_i   (clear_ni),
        .active_o (hold_active),
        .remain_o (hold_remain),
        .pulse_o  (pulse_o),
        .pulse_no (pulse_no)
    );

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
    parameter int LEN_W  = 8,
    parameter bit RETRIG = 1'b1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clr_sync,
    input logic [2:0]       fire_ev,
    input logic             fire,
    input logic             active,
    input logic [LEN_W-1:0] remain,
    input logic [LEN_W-1:0] len_i
);

    // R4: low synchronised clear always empties the machine
    p_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_sync |=> !active);

    // R12: idle persists without a trigger event
    p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active && !fire) |=> !active);

    // R6: a start loads the count from len_i
    p_start_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active && fire && clr_sync && (len_i != '0))
        |=> (active && (remain == LEN_W'($past(len_i) - 1'b1))));

    // R10: zero length does not start
    p_zero_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active && fire && (len_i == '0)) |=> !active);

    // R9: each event source is single-cycle
    p_ev_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|fire_ev) |=> ((fire_ev & $past(fire_ev)) == 3'b000));

    generate
        if (RETRIG) begin : g_retrig
            // R7: retrigger reloads
            p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (active && fire && clr_sync && (len_i != '0))
                |=> (active && (remain == LEN_W'($past(len_i) - 1'b1))));
        end else begin : g_noretrig
            // R8: counting is undisturbed by triggers
            p_nocount_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (active && clr_sync && (remain != '0))
                |=> (active && (remain == LEN_W'($past(remain) - 1'b1))));
            // R8: expiry regardless of triggers
            p_expire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (active && (remain == '0)) |=> !active);
        end
    endgenerate

endmodule

bind oneshot_pulse oneshot_pulse_chk #(
    .LEN_W  (LEN_W),
    .RETRIG (RETRIG)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_sync (clr_sync),
    .fire_ev  (fire_ev),
    .fire     (fire_any),
    .active   (hold_active),
    .remain   (hold_remain),
    .len_i    (len_i)
);

// File: tb/oneshot_pulse_tb_top.sv
module oneshot_pulse_tb_top;

    localparam time CLK_PERIOD = 10;
    localparam int  LEN_W      = 8;

    typedef struct packed {
        logic             act;
        logic [LEN_W-1:0] rem;
    } model_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             a = 1'b0;
    logic             b = 1'b1;
    logic             c = 1'b1;
    logic [LEN_W-1:0] len = 8'd5;
    logic             p_r, pn_r, p_n, pn_n;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oneshot_pulse #(.LEN_W(LEN_W), .RETRIG(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fire_fall_i(a), .fire_rise_i(b),
        .clear_ni(c), .len_i(len), .pulse_o(p_r), .pulse_no(pn_r));

    oneshot_pulse #(.LEN_W(LEN_W), .RETRIG(1'b0)) dut_nr_i (
        .clk_i(clk), .rst_ni(rst_n), .fire_fall_i(a), .fire_rise_i(b),
        .clear_ni(c), .len_i(len), .pulse_o(p_n), .pulse_no(pn_n));

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference functions written from the requirements
    function automatic logic model_event(logic [2:0] ah, logic [2:0] bh, logic [2:0] ch);
        return (ah[2] & ~ah[1] & bh[1]) | (bh[1] & ~bh[2] & ~ah[1]) | (ch[1] & ~ch[2]);
    endfunction

    function automatic model_t model_step(model_t cur, logic ev, logic kill,
                                          logic [LEN_W-1:0] l, logic retrig);
        model_t nx = cur;
        if (kill) begin
            nx.act = 1'b0;
            nx.rem = '0;
        end else if (!cur.act) begin
            if (ev && l != '0) begin
                nx.act = 1'b1;
                nx.rem = l - 1'b1;
            end
        end else if (retrig && ev && l != '0) begin
            nx.rem = l - 1'b1;
        end else if (cur.rem == '0) begin
            nx.act = 1'b0;
        end else begin
            nx.rem = cur.rem - 1'b1;
        end
        return nx;
    endfunction

    logic [2:0] ah, bh, ch;
    model_t     mr, mn;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ah <= 3'b000; bh <= 3'b111; ch <= 3'b111;
            mr <= '0;     mn <= '0;
        end else begin
            mr <= model_step(mr, model_event(ah, bh, ch), ~ch[1], len, 1'b1);
            mn <= model_step(mn, model_event(ah, bh, ch), ~ch[1], len, 1'b0);
            ah <= {ah[1:0], a};
            bh <= {bh[1:0], b};
            ch <= {ch[1:0], c};
        end
    end

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(p_r === (mr.act & c), "R7 model retrig", p_r, mr.act & c);
            check(p_n === (mn.act & c), "R8 model nonretrig", p_n, mn.act & c);
            check(pn_r === ~p_r, "R11 retrig complement", pn_r, ~p_r);
            check(pn_n === ~p_n, "R11 nonretrig complement", pn_n, ~p_n);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic idle_setup();
        a = 1'b1; b = 1'b1; c = 1'b1;
        tick(8);
    endtask

    task automatic expect_latency(input string tag);
        tick(1); check(p_r == 1'b0, tag, p_r, 0);
        tick(1); check(p_r == 1'b0, tag, p_r, 0);
        tick(1); check(p_r == 1'b1 && p_n == 1'b1, tag, p_r & p_n, 1);
    endtask

    task automatic count_high(input int win, output int cr, output int cn);
        cr = 0; cn = 0;
        repeat (win) begin
            cr += int'(p_r);
            cn += int'(p_n);
            tick(1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_err++;
        $display("FAIL watchdog R12: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int cr, cn;
        void'($urandom(32'd7001));
        tick(3);
        // R12 reset state
        check(p_r == 1'b0 && pn_r == 1'b1, "R12 reset", p_r, 0);
        rst_n = 1'b1;
        count_high(10, cr, cn);
        check(cr == 0 && cn == 0, "R12 quiet after reset", cr + cn, 0);

        // R1 fall trigger
        len = 8'd5; idle_setup();
        a = 1'b0; expect_latency("R1 latency");
        count_high(20, cr, cn);
        check(cr == 5, "R6 len 5 retrig", cr, 5);
        check(cn == 5, "R6 len 5 nonretrig", cn, 5);

        // R2 rise trigger with fall input low
        b = 1'b0; tick(6); len = 8'd7;
        b = 1'b1; expect_latency("R2 latency");
        count_high(20, cr, cn);
        check(cr == 7 && cn == 7, "R6 len 7", cr, 7);

        // R3 clear release
        c = 1'b0; tick(6); len = 8'd4;
        c = 1'b1; expect_latency("R3 latency");
        count_high(20, cr, cn);
        check(cr == 4 && cn == 4, "R3 release pulse length", cr, 4);

        // R5 immediate gating, R4 abort of the old pulse
        len = 8'd20; idle_setup();
        a = 1'b0; tick(5);
        c = 1'b0; #1;
        check(p_r == 1'b0 && pn_r == 1'b1 && p_n == 1'b0, "R5 clear gates output", p_r, 0);
        len = 8'd4; tick(6);
        c = 1'b1; tick(1);
        count_high(40, cr, cn);
        check(cr == 4, "R4 abort retrig", cr, 4);
        check(cn == 4, "R4 abort nonretrig", cn, 4);

        // R4 triggers while clear low
        c = 1'b0; a = 1'b1; b = 1'b1; tick(4);
        a = 1'b0;
        count_high(10, cr, cn);
        check(cr == 0 && cn == 0, "R4 trigger under clear", cr + cn, 0);
        c = 1'b1; tick(20);

        // R9 unqualified edges
        idle_setup();
        b = 1'b0; count_high(12, cr, cn);
        check(cr + cn == 0, "R9 rise input falling", cr + cn, 0);
        a = 1'b0; count_high(12, cr, cn);
        check(cr + cn == 0, "R9 fall with rise input low", cr + cn, 0);
        a = 1'b1; count_high(12, cr, cn);
        check(cr + cn == 0, "R9 fall input rising", cr + cn, 0);
        b = 1'b1; count_high(12, cr, cn);
        check(cr + cn == 0, "R9 rise with fall input high", cr + cn, 0);

        // R10 zero length
        len = 8'd0; idle_setup();
        a = 1'b0; count_high(12, cr, cn);
        check(cr + cn == 0, "R10 zero length", cr + cn, 0);

        // R7 / R8 retrigger three cycles in
        len = 8'd6; idle_setup();
        a = 1'b0; tick(1);
        b = 1'b0; tick(2);
        b = 1'b1;
        count_high(40, cr, cn);
        check(cr == 9, "R7 restart length", cr, 9);
        check(cn == 6, "R8 ignored retrigger", cn, 6);

        // Constrained random phase checked by the reference
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 8 == 0)  a = ~a;
            if ($urandom % 8 == 0)  b = ~b;
            if ($urandom % 40 == 0) c = ~c;
            if ($urandom % 16 == 0) len = LEN_W'($urandom % 12);
            tick(1);
        end
        c = 1'b1; tick(30);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule